// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block holds the exception state of a 32-bit control coprocessor and decides when the pipeline must be redirected into the exception handler. Each cycle it can receive one synchronous fault report from the pipeline, and it can also be asked to check the external interrupt line. When it takes an exception, it updates four registers: the cause word, the status word, the return address, and (for misaligned accesses) the faulting data address. One cycle later it raises a redirect strobe carrying the handler address. Alongside that strobe it raises a squash flag, which tells the pipeline to drop any pending branch target and any pending delayed register load.

The block also performs the return-from-exception step. That step pops the three-level kernel/interrupt-enable stack held in the six low status bits. Software reaches the registers through a combinational read port and a synchronous write port, both indexed by register number. All pins are plain control pins. A fault report, check strobe, return strobe or register write is accepted in the cycle it is presented, so there is no back-pressure and no valid/ready handshake.

Top module: `exc_ctrl`

## Requirements
- R1: A synchronous request carries its cause code on `exc_code`. The codes used are 4 (misaligned load), 5 (misaligned store), 8 (system call), 9 (breakpoint), 10 (undefined opcode) and 12 (signed overflow). Entry writes this code into cause bits 6:2. An interrupt entry writes code 0.
- R2: On entry, cause bit 31 takes the branch-delay flag, cause bits 30:8 keep their value, and cause bits 7 and 1:0 become zero.
- R3: On entry, status bits 5:0 are pushed as a stack: old bits 3:2 move to 5:4, old bits 1:0 move to 3:2, and bits 1:0 are cleared. Status bits 31:6 are unchanged.
- R4: One cycle after an entry, `redirect` and `squash` are high for exactly that cycle. `redirect_vec` is 0xBFC00180 when status bit 22 is set, and 0x80000080 otherwise.
- R5: For a synchronous request, the return address register (index 14) takes `exc_pc`, and cause bit 31 takes `exc_in_delay`.
- R6: For an interrupt entry, the return address is `next_pc`, or `next_pc` minus 4 when `branch_pending` is high. Cause bit 31 takes `branch_pending`.
- R7: Every cycle with `irq_check` high copies `irq_line` into cause bit 10.
- R8: An interrupt entry occurs only when `irq_check` and `irq_line` are high and status bits 10 and 0 are both set.
- R9: A synchronous request wins over an interrupt in the same cycle. In an entry cycle, `rfe` and register writes have no effect.
- R10: `rfe` without an entry copies status bits 5:2 into bits 3:0 and leaves bits 5:4 unchanged.
- R11: The fault address register (index 8) takes `exc_addr` only on entries with code 4 or 5. Otherwise it holds its value.
- R12: Register writes behave as follows:
  - Index 12 writes all status bits.
  - Index 13 writes only cause bits 9:8.
  - Writes to indices 8 and 14 are ignored.
  - Reads of any index other than 8, 12, 13 and 14 return zero.
- R13: After reset, status reads 0x00400000, the other three registers read zero, and `redirect` and `squash` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Synchronous fault report this cycle |
| exc_code | input | 5 | Cause code of the reported fault |
| exc_in_delay | input | 1 | Faulting instruction sits in a branch delay slot |
| exc_pc | input | 32 | Address of the faulting instruction |
| exc_addr | input | 32 | Data address of a misaligned access |
| irq_check | input | 1 | Sample the interrupt line this cycle |
| irq_line | input | 1 | External interrupt-pending level |
| next_pc | input | 32 | Address of the next instruction, used for interrupts |
| branch_pending | input | 1 | A branch target is pending at the interrupt point |
| rfe | input | 1 | Return-from-exception stack pop |
| reg_we | input | 1 | Register write enable |
| reg_widx | input | 5 | Register write index |
| reg_wdata | input | 32 | Register write data |
| reg_ridx | input | 5 | Register read index |
| reg_rdata | output | 32 | Register read data (combinational) |
| redirect | output | 1 | One-cycle handler redirect strobe |
| redirect_vec | output | 32 | Handler address |
| squash | output | 1 | Drop pending branch target and delayed load |

## Verification
The bench targets an interrupt taken while a branch is pending. A design that got this wrong would return to the branch target instead of the branch, or leave the delay flag clear. It also collides a fault with an interrupt, a return and a status write in one cycle. A wrong priority would record code 0, pop instead of push, or let the write overwrite the pushed stack. The bench flips the boot-vector bit between entries to catch a vector chosen from stale state. It pushes every value through the cause write port to catch read-only cause bits that leak. Finally, it checks that the fault address moves only for the two misaligned codes, and that the return pop leaves bits 5:4 in place.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;

  // cause codes recorded in the cause word
  localparam logic [4:0] CODE_IRQ         = 5'd0;
  localparam logic [4:0] CODE_LOAD_ALIGN  = 5'd4;
  localparam logic [4:0] CODE_STORE_ALIGN = 5'd5;
  localparam logic [4:0] CODE_SYSCALL     = 5'd8;
  localparam logic [4:0] CODE_BREAK       = 5'd9;
  localparam logic [4:0] CODE_BAD_OP      = 5'd10;
  localparam logic [4:0] CODE_OVF         = 5'd12;

  // register numbers seen by the move instructions
  localparam logic [4:0] IDX_FAULT_ADDR = 5'd8;
  localparam logic [4:0] IDX_STATUS     = 5'd12;
  localparam logic [4:0] IDX_CAUSE      = 5'd13;
  localparam logic [4:0] IDX_RET_ADDR   = 5'd14;

  localparam int MODE_W = 6;

  function automatic logic [MODE_W-1:0] mode_push(input logic [MODE_W-1:0] s);
    return {s[3:0], 2'b00};
  endfunction

  function automatic logic [MODE_W-1:0] mode_pop(input logic [MODE_W-1:0] s);
    return {s[5:4], s[5:2]};
  endfunction

  function automatic logic is_align_code(input logic [4:0] c);
    return (c == CODE_LOAD_ALIGN) || (c == CODE_STORE_ALIGN);
  endfunction

endpackage

// File: rtl/exc_select.sv
module exc_select
  import exc_ctrl_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int IE_POS   = 0,
  parameter int MASK_POS = 10
) (
  input  logic            exc_valid,
  input  logic [4:0]      exc_code,
  input  logic            exc_in_delay,
  input  logic [XLEN-1:0] exc_pc,
  input  logic            irq_check,
  input  logic            irq_line,
  input  logic [XLEN-1:0] next_pc,
  input  logic            branch_pending,
  input  logic [XLEN-1:0] status,
  output logic            take,
  output logic [4:0]      take_code,
  output logic            take_bd,
  output logic [XLEN-1:0] take_ret,
  output logic            take_align
);
  localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);

  logic irq_go;

  always_comb begin
    irq_go     = irq_check && irq_line && status[IE_POS] && status[MASK_POS];
    take       = exc_valid || irq_go;
    take_code  = CODE_IRQ;
    take_bd    = branch_pending;
    take_ret   = branch_pending ? (next_pc - WORD_BYTES) : next_pc;
    take_align = 1'b0;
    if (exc_valid) begin
      take_code  = exc_code;
      take_bd    = exc_in_delay;
      take_ret   = exc_pc;
      take_align = is_align_code(exc_code);
    end
  end

endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg
  import exc_ctrl_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VAL = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic            wr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= RESET_VAL;
    end else if (push) begin
      q[MODE_W-1:0] <= mode_push(q[MODE_W-1:0]);
    end else if (pop) begin
      q[MODE_W-1:0] <= mode_pop(q[MODE_W-1:0]);
    end else if (wr) begin
      q <= wdata;
    end
  end

endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg #(
  parameter int XLEN     = 32,
  parameter int PEND_POS = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample,
  input  logic            line,
  input  logic            take,
  input  logic            take_bd,
  input  logic [4:0]      take_code,
  input  logic            sw_wr,
  input  logic [1:0]      sw_bits,
  output logic [XLEN-1:0] q
);
  logic [XLEN-1:0] nxt;

  always_comb begin
    nxt = q;
    if (sample) nxt[PEND_POS] = line;
    if (take) begin
      nxt = {take_bd, nxt[XLEN-2:8], 1'b0, take_code, 2'b00};
    end else if (sw_wr) begin
      nxt[9:8] = sw_bits;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_ctrl_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              BEV_POS   = 22,
  parameter int              IE_POS    = 0,
  parameter int              MASK_POS  = 10,
  parameter int              PEND_POS  = 10,
  parameter logic [XLEN-1:0] VEC_BOOT  = 32'hBFC0_0180,
  parameter logic [XLEN-1:0] VEC_MAIN  = 32'h8000_0080,
  parameter logic [XLEN-1:0] SR_RESET  = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_valid,
  input  logic [4:0]      exc_code,
  input  logic            exc_in_delay,
  input  logic [XLEN-1:0] exc_pc,
  input  logic [XLEN-1:0] exc_addr,
  input  logic            irq_check,
  input  logic            irq_line,
  input  logic [XLEN-1:0] next_pc,
  input  logic            branch_pending,
  input  logic            rfe,
  input  logic            reg_we,
  input  logic [4:0]      reg_widx,
  input  logic [XLEN-1:0] reg_wdata,
  input  logic [4:0]      reg_ridx,
  output logic [XLEN-1:0] reg_rdata,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_vec,
  output logic            squash
);
  logic            take;
  logic [4:0]      take_code;
  logic            take_bd;
  logic [XLEN-1:0] take_ret;
  logic            take_align;
  logic [XLEN-1:0] sr_q;
  logic [XLEN-1:0] cause_q;
  logic [XLEN-1:0] epc_q;
  logic [XLEN-1:0] bad_q;
  logic            sr_wr;
  logic            cause_wr;

  exc_select #(.XLEN(XLEN), .IE_POS(IE_POS), .MASK_POS(MASK_POS)) sel_i (
    .exc_valid      (exc_valid),
    .exc_code       (exc_code),
    .exc_in_delay   (exc_in_delay),
    .exc_pc         (exc_pc),
    .irq_check      (irq_check),
    .irq_line       (irq_line),
    .next_pc        (next_pc),
    .branch_pending (branch_pending),
    .status         (sr_q),
    .take           (take),
    .take_code      (take_code),
    .take_bd        (take_bd),
    .take_ret       (take_ret),
    .take_align     (take_align)
  );

  assign sr_wr    = reg_we && (reg_widx == IDX_STATUS);
  assign cause_wr = reg_we && (reg_widx == IDX_CAUSE);

  exc_status_reg #(.XLEN(XLEN), .RESET_VAL(SR_RESET)) sr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (take),
    .pop   (rfe),
    .wr    (sr_wr),
    .wdata (reg_wdata),
    .q     (sr_q)
  );

  exc_cause_reg #(.XLEN(XLEN), .PEND_POS(PEND_POS)) cause_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample    (irq_check),
    .line      (irq_line),
    .take      (take),
    .take_bd   (take_bd),
    .take_code (take_code),
    .sw_wr     (cause_wr),
    .sw_bits   (reg_wdata[9:8]),
    .q         (cause_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q        <= '0;
      bad_q        <= '0;
      redirect     <= 1'b0;
      redirect_vec <= VEC_MAIN;
    end else begin
      redirect <= take;
      if (take) begin
        epc_q        <= take_ret;
        redirect_vec <= sr_q[BEV_POS] ? VEC_BOOT : VEC_MAIN;
        if (take_align) bad_q <= exc_addr;
      end
    end
  end

  assign squash = redirect;

  always_comb begin
    unique case (reg_ridx)
      IDX_FAULT_ADDR: reg_rdata = bad_q;
      IDX_STATUS:     reg_rdata = sr_q;
      IDX_CAUSE:      reg_rdata = cause_q;
      IDX_RET_ADDR:   reg_rdata = epc_q;
      default:        reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int              XLEN     = 32,
  parameter int              BEV_POS  = 22,
  parameter int              IE_POS   = 0,
  parameter int              MASK_POS = 10,
  parameter int              PEND_POS = 10,
  parameter logic [XLEN-1:0] VEC_BOOT = 32'hBFC0_0180,
  parameter logic [XLEN-1:0] VEC_MAIN = 32'h8000_0080
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_valid,
  input logic [4:0]      exc_code,
  input logic [XLEN-1:0] exc_pc,
  input logic            irq_check,
  input logic            irq_line,
  input logic            rfe,
  input logic            redirect,
  input logic [XLEN-1:0] redirect_vec,
  input logic            squash,
  input logic [XLEN-1:0] sr_q,
  input logic [XLEN-1:0] cause_q,
  input logic [XLEN-1:0] epc_q,
  input logic [XLEN-1:0] bad_q
);
  // R4
  redirect_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (redirect && squash));

  // R4
  vector_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (redirect_vec == (sr_q[BEV_POS] ? VEC_BOOT : VEC_MAIN)));

  // R3
  mode_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (sr_q[5:0] == {$past(sr_q[3:0]), 2'b00}));

  // R5
  sync_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (epc_q == $past(exc_pc)));

  // R1
  sync_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (cause_q[6:2] == $past(exc_code)));

  // R7
  pend_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_check |=> (cause_q[PEND_POS] == $past(irq_line)));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_check && !exc_valid && !(irq_line && sr_q[IE_POS] && sr_q[MASK_POS])) |=> !redirect);

  // R10
  mode_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe && !exc_valid && !irq_check) |=> (sr_q[5:0] == {$past(sr_q[5:4]), $past(sr_q[5:2])}));

  // R11
  badaddr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && (exc_code != 5'd4) && (exc_code != 5'd5)) |=> $stable(bad_q));

endmodule

bind exc_ctrl exc_ctrl_chk #(
  .XLEN(XLEN), .BEV_POS(BEV_POS), .IE_POS(IE_POS), .MASK_POS(MASK_POS),
  .PEND_POS(PEND_POS), .VEC_BOOT(VEC_BOOT), .VEC_MAIN(VEC_MAIN)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .exc_valid    (exc_valid),
  .exc_code     (exc_code),
  .exc_pc       (exc_pc),
  .irq_check    (irq_check),
  .irq_line     (irq_line),
  .rfe          (rfe),
  .redirect     (redirect),
  .redirect_vec (redirect_vec),
  .squash       (squash),
  .sr_q         (sr_q),
  .cause_q      (cause_q),
  .epc_q        (epc_q),
  .bad_q        (bad_q)
);

// File: tb/exc_ctrl_tb.sv
module exc_ctrl_tb_top;
  localparam logic [31:0] VBOOT = 32'hBFC0_0180;
  localparam logic [31:0] VMAIN = 32'h8000_0080;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_valid, exc_in_delay, irq_check, irq_line, branch_pending, rfe, reg_we;
  logic [4:0]  exc_code, reg_widx, reg_ridx;
  logic [31:0] exc_pc, exc_addr, next_pc, reg_wdata, reg_rdata, redirect_vec;
  logic        redirect, squash;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_sr, m_cause, m_epc, m_bad, m_vec;
  logic        m_redir;

  always #10 clk = ~clk;

  exc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
    .exc_in_delay(exc_in_delay), .exc_pc(exc_pc), .exc_addr(exc_addr),
    .irq_check(irq_check), .irq_line(irq_line), .next_pc(next_pc),
    .branch_pending(branch_pending), .rfe(rfe), .reg_we(reg_we),
    .reg_widx(reg_widx), .reg_wdata(reg_wdata), .reg_ridx(reg_ridx),
    .reg_rdata(reg_rdata), .redirect(redirect), .redirect_vec(redirect_vec),
    .squash(squash)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] idx, output logic [31:0] v);
    reg_ridx = idx;
    #1;
    v = reg_rdata;
  endtask

  task automatic idle();
    exc_valid = 0; exc_code = 0; exc_in_delay = 0; exc_pc = 0; exc_addr = 0;
    irq_check = 0; irq_line = 0; next_pc = 0; branch_pending = 0; rfe = 0;
    reg_we = 0; reg_widx = 0; reg_wdata = 0;
  endtask

  function automatic logic [4:0] pick_code(input int n);
    case (n % 6)
      0: return 5'd4;
      1: return 5'd5;
      2: return 5'd8;
      3: return 5'd9;
      4: return 5'd10;
      default: return 5'd12;
    endcase
  endfunction

  task automatic model_step();
    logic ts, ti, bd;
    logic [4:0]  code;
    logic [31:0] nc, ns;
    ts = exc_valid;
    ti = irq_check && irq_line && m_sr[10] && m_sr[0] && !exc_valid;
    nc = m_cause;
    ns = m_sr;
    if (irq_check) nc[10] = irq_line;
    m_redir = ts || ti;
    if (m_redir) begin
      m_vec = m_sr[22] ? VBOOT : VMAIN;
      code  = ts ? exc_code : 5'd0;
      bd    = ts ? exc_in_delay : branch_pending;
      nc    = {bd, nc[30:8], 1'b0, code, 2'b00};
      ns[5:0] = {m_sr[3:0], 2'b00};
      m_epc = ts ? exc_pc : (branch_pending ? next_pc - 32'd4 : next_pc);
      if (ts && (code == 5'd4 || code == 5'd5)) m_bad = exc_addr;
    end else begin
      if (rfe) ns[3:0] = m_sr[5:2];
      else if (reg_we && reg_widx == 5'd12) ns = reg_wdata;
      if (reg_we && reg_widx == 5'd13) nc[9:8] = reg_wdata[9:8];
    end
    m_sr = ns;
    m_cause = nc;
  endtask

  task automatic step();
    logic [31:0] v;
    model_step();
    @(posedge clk);
    @(negedge clk);
    idle();
    check("R4 redirect", {31'd0, redirect}, {31'd0, m_redir});
    check("R4 squash", {31'd0, squash}, {31'd0, m_redir});
    if (m_redir) check("R4 vector", redirect_vec, m_vec);
    rd(5'd12, v); check("R3 R9 R10 R12 status", v, m_sr);
    rd(5'd13, v); check("R1 R2 R7 R12 cause", v, m_cause);
    rd(5'd14, v); check("R5 R6 R12 return address", v, m_epc);
    rd(5'd8,  v); check("R11 R12 fault address", v, m_bad);
    rd(5'd3,  v); check("R12 unmapped read", v, 32'd0);
  endtask

  task automatic write_sr(input logic [31:0] d);
    reg_we = 1; reg_widx = 5'd12; reg_wdata = d;
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int seed;
    seed = $urandom(32'd4242);
    idle();
    reg_ridx = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13 reset state
    rd(5'd12, v); check("R13 status reset", v, 32'h0040_0000);
    rd(5'd13, v); check("R13 cause reset", v, 32'd0);
    rd(5'd14, v); check("R13 return reset", v, 32'd0);
    rd(5'd8,  v); check("R13 fault reset", v, 32'd0);
    check("R13 redirect reset", {30'd0, redirect, squash}, 32'd0);
    rst_n = 1;
    m_sr = 32'h0040_0000; m_cause = 0; m_epc = 0; m_bad = 0; m_vec = VMAIN; m_redir = 0;

    // R8 R6 interrupt between instructions, main vector
    write_sr(32'h0000_0401);
    irq_check = 1; irq_line = 1; next_pc = 32'h0000_0100;
    step();
    check("R6 interrupt return", m_epc, 32'h0000_0100);
    rd(5'd13, v); check("R1 R7 interrupt code and pending", v & 32'h8000_047C, 32'h0000_0400);
    check("R4 main vector", redirect_vec, VMAIN);
    rd(5'd12, v); check("R3 pushed stack", v[5:0], 32'h04);

    // R6 interrupt with pending branch
    write_sr(32'h0000_0401);
    irq_check = 1; irq_line = 1; next_pc = 32'h0000_0200; branch_pending = 1;
    step();
    rd(5'd14, v); check("R6 interrupt in delay", v, 32'h0000_01FC);
    rd(5'd13, v); check("R2 delay flag", v[31], 1);

    // R8 masked interrupt: line sampled, no entry
    write_sr(32'h0000_0400);
    irq_check = 1; irq_line = 1; next_pc = 32'h0000_0300;
    step();
    check("R8 masked no redirect", {31'd0, redirect}, 32'd0);

    // R9 collision: fault + interrupt + return + status write
    write_sr(32'h0000_0425);
    exc_valid = 1; exc_code = 5'd12; exc_pc = 32'h0000_1000;
    irq_check = 1; irq_line = 1; next_pc = 32'h0000_2000; rfe = 1;
    reg_we = 1; reg_widx = 5'd12; reg_wdata = 32'hFFFF_FFFF;
    step();
    rd(5'd12, v); check("R9 push wins", v, 32'h0000_0414);
    rd(5'd13, v); check("R9 sync code wins", v[6:2], 32'd12);

    // R10 pop leaves 5:4
    write_sr(32'h0000_0024);
    rfe = 1;
    step();
    rd(5'd12, v); check("R10 pop", v, 32'h0000_0029);

    // R11 misaligned load then syscall, boot vector
    write_sr(32'h0040_0000);
    exc_valid = 1; exc_code = 5'd4; exc_pc = 32'h40; exc_addr = 32'h1234_5679;
    step();
    check("R4 boot vector", redirect_vec, VBOOT);
    exc_valid = 1; exc_code = 5'd8; exc_pc = 32'h44; exc_addr = 32'hDEAD_BEEF;
    step();
    rd(5'd8, v); check("R11 fault address kept", v, 32'h1234_5679);

    // R12 cause and return-address writes
    reg_we = 1; reg_widx = 5'd13; reg_wdata = 32'hFFFF_FFFF;
    step();
    reg_we = 1; reg_widx = 5'd14; reg_wdata = 32'h5555_5555;
    step();
    rd(5'd14, v); check("R12 return write ignored", v, 32'h0000_0044);

    // R1 every code, then mixed random traffic
    for (int i = 0; i < 6; i++) begin
      exc_valid = 1; exc_code = pick_code(i); exc_pc = 32'h100 + 32'(i * 4);
      exc_addr = 32'hA000_0000 + 32'(i); exc_in_delay = i[0];
      step();
    end
    for (int i = 0; i < 3000; i++) begin
      exc_valid = ($urandom % 4) == 0;
      exc_code = pick_code(int'($urandom % 6));
      exc_in_delay = $urandom % 2;
      exc_pc = $urandom & 32'hFFFF_FFFC;
      exc_addr = $urandom;
      irq_check = $urandom % 2;
      irq_line = $urandom % 2;
      next_pc = $urandom & 32'hFFFF_FFFC;
      branch_pending = $urandom % 2;
      rfe = ($urandom % 8) == 0;
      reg_we = ($urandom % 6) == 0;
      case ($urandom % 5)
        0: reg_widx = 5'd8;
        1: reg_widx = 5'd12;
        2: reg_widx = 5'd13;
        3: reg_widx = 5'd14;
        default: reg_widx = 5'd3;
      endcase
      reg_wdata = $urandom;
      if (reg_widx == 5'd12) reg_wdata[10] = ($urandom % 4) != 0;
      step();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule